// File: doc/BRIEF.md
# Two-Phase Page Transfer Engine

This block moves one fixed-size page between a byte-wide flash data port and host memory, staging it in an on-board page buffer. Every transfer has two phases. The internal phase moves the page between the flash port and the buffer. The memory phase moves it between the buffer and a host address, one 32-bit beat at a time, over a simple request/acknowledge interface. Software starts each phase on its own, by writing the settings register, and waits for that phase's done interrupt before it starts the next.

For a page read, software first runs the internal phase, which fills the buffer from flash. It then runs the memory phase, which copies the buffer out to the host. For a page write the order is reversed: host into the buffer first, then buffer out to flash.

If the memory side reports an error, the engine abandons the phase and raises an error interrupt. Writing zero to the settings register stops the engine at any point, so that software can park the address register on a safe value.

Top module: `page_dma_engine`

## Requirements
- R1: After a synchronous active-low reset, all four registers read zero, `irq` is low, and neither `mem_req`, `flash_rd` nor `flash_wr` is asserted.
- R2: Register index 0 holds the settings: bit 0 selects read direction, bit 1 selects the internal phase, bit 2 selects the memory phase. A write that sets exactly one phase bit starts that phase from the first byte. Any other written value stops the engine and leaves the status register unchanged. Only one phase is ever active.
- R3: In read direction, the internal phase performs 512 flash reads and stores the bytes in buffer order. In write direction, it presents the 512 buffer bytes on `flash_wdata` in order, with `flash_wr`. Flash transfers happen only in cycles where `flash_rdy` is high.
- R4: The memory phase performs 128 beats of 32 bits. Beat i carries buffer bytes 4i to 4i+3, with byte 4i in bits 7:0 (little-endian). In read direction the beats are host writes (`mem_we`=1); in write direction they are host reads. A request is held, with a stable address, until `mem_ack` or `mem_err`.
- R5: Register index 1 is the 32-bit host address. It is driven on `mem_addr` and advances by 4 on every acknowledged beat without error. Software places it on a 512-byte boundary before the memory phase.
- R6: When a phase completes, it sets its done bit in the status register (bit 0 for internal, bit 1 for memory). The engine then stays idle until the settings register is written again.
- R7: A `mem_err` during a request sets status bit 2. The address does not advance, no data is stored for that beat, and the engine goes idle in the next cycle.
- R8: Register index 3 is the status register. Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged. A completion event in the same cycle as a clear wins.
- R9: Register index 2 holds the interrupt enables, at the same bit positions as the status bits. `irq` is high exactly when some status bit and its enable are both set.
- R10: Writing zero to the settings register in the middle of a phase ends all flash and memory activity from the next cycle on, and sets no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the indexed register |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Host memory beat request |
| mem_we | output | 1 | 1 = host write, 0 = host read |
| mem_addr | output | 32 | Host byte address of the beat |
| mem_wdata | output | 32 | Beat data towards the host |
| mem_rdata | input | 32 | Beat data from the host |
| mem_ack | input | 1 | Beat accepted |
| mem_err | input | 1 | Beat failed |
| flash_rdy | input | 1 | Flash port can move a byte this cycle |
| flash_rd | output | 1 | Byte taken from `flash_rdata` |
| flash_rdata | input | 8 | Byte from flash |
| flash_wr | output | 1 | Byte on `flash_wdata` is valid |
| flash_wdata | output | 8 | Byte to flash |

## Verification
Full page round trips are run in both directions at several aligned host addresses, with distinct data seeds, and with `flash_rdy` dropping one cycle in four. Byte ordering, beat packing and per-phase done bits must hold across differing page contents and addresses. An error is injected on the sixth beat, which separates an abort that still advances the address or stores data from a clean one. A stop is issued mid-phase, and a settings value with both phase bits set is written; together these show that activity really ceases without a false completion. Masked and unmasked interrupts, and partial write-one-to-clear, separate the enable logic from the status logic.

// File: rtl/pdma_pkg.sv
// Package: register indices, bit positions and phase encoding shared by
// the page transfer engine and its checker.
package pdma_pkg;
    localparam logic [1:0] REG_SET  = 2'd0;
    localparam logic [1:0] REG_ADDR = 2'd1;
    localparam logic [1:0] REG_IEN  = 2'd2;
    localparam logic [1:0] REG_STA  = 2'd3;

    localparam int SET_RD  = 0;
    localparam int SET_INT = 1;
    localparam int SET_MEM = 2;

    localparam int ST_INT = 0;
    localparam int ST_MEM = 1;
    localparam int ST_ERR = 2;

    typedef enum logic [1:0] {PH_IDLE, PH_INT, PH_MEM} phase_t;
endpackage

// File: rtl/pdma_regs.sv
// Register file of the page engine: settings, host address, interrupt
// enables and write-one-to-clear status. Decodes settings writes into
// start/stop commands. Assumes one register access per cycle.
module pdma_regs #(
    parameter int DATA_W     = 32,
    parameter int BEAT_BYTES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              addr_inc,
    input  logic              ev_int_done,
    input  logic              ev_mem_done,
    input  logic              ev_err,
    output logic              dir_read,
    output logic              start_int,
    output logic              start_mem,
    output logic              stop,
    output logic [DATA_W-1:0] cur_addr,
    output logic              irq
);
    import pdma_pkg::*;

    logic [2:0] settings_q;
    logic [2:0] ien_q;
    logic [2:0] sta_q;
    logic [2:0] sta_set;
    logic       set_wr;

    // Decode a settings write into a phase start or an engine stop
    always_comb begin
        set_wr    = reg_we && (reg_addr == REG_SET);
        start_int = set_wr && reg_wdata[SET_INT] && !reg_wdata[SET_MEM];
        start_mem = set_wr && reg_wdata[SET_MEM] && !reg_wdata[SET_INT];
        stop      = set_wr && !(reg_wdata[SET_INT] ^ reg_wdata[SET_MEM]);
        sta_set   = '0;
        sta_set[ST_INT] = ev_int_done;
        sta_set[ST_MEM] = ev_mem_done;
        sta_set[ST_ERR] = ev_err;
    end

    // Settings, enables, address and status registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settings_q <= '0;
            ien_q      <= '0;
            sta_q      <= '0;
            cur_addr   <= '0;
        end else begin
            if (set_wr)
                settings_q <= reg_wdata[2:0];
            if (reg_we && reg_addr == REG_IEN)
                ien_q <= reg_wdata[2:0];
            if (reg_we && reg_addr == REG_ADDR)
                cur_addr <= reg_wdata;
            else if (addr_inc)
                cur_addr <= cur_addr + DATA_W'(BEAT_BYTES);
            if (reg_we && reg_addr == REG_STA)
                sta_q <= (sta_q & ~reg_wdata[2:0]) | sta_set;
            else
                sta_q <= sta_q | sta_set;
        end
    end

    // Read mux, direction and interrupt output
    always_comb begin
        dir_read = settings_q[SET_RD];
        irq      = |(sta_q & ien_q);
        case (reg_addr)
            REG_SET:  reg_rdata = DATA_W'(settings_q);
            REG_ADDR: reg_rdata = cur_addr;
            REG_IEN:  reg_rdata = DATA_W'(ien_q);
            default:  reg_rdata = DATA_W'(sta_q);
        endcase
    end
endmodule

// File: rtl/pdma_pagebuf.sv
// On-board page buffer: byte access from the flash side, beat-wide access
// from the memory side, little-endian within a beat. Reads are
// combinational. The two write ports are never active in the same cycle.
module pdma_pagebuf #(
    parameter int PAGE_BYTES = 512,
    parameter int BEAT_BYTES = 4
) (
    input  logic                          clk,
    input  logic                          byte_we,
    input  logic [$clog2(PAGE_BYTES)-1:0] byte_idx,
    input  logic [7:0]                    byte_wdata,
    output logic [7:0]                    byte_rdata,
    input  logic                          word_we,
    input  logic [$clog2(PAGE_BYTES/BEAT_BYTES)-1:0] word_idx,
    input  logic [8*BEAT_BYTES-1:0]       word_wdata,
    output logic [8*BEAT_BYTES-1:0]       word_rdata
);
    localparam int LANE_W = $clog2(BEAT_BYTES);

    logic [7:0] mem_q [PAGE_BYTES];

    // Store one flash byte or one memory beat
    always_ff @(posedge clk) begin
        if (byte_we)
            mem_q[byte_idx] <= byte_wdata;
        else if (word_we)
            for (int j = 0; j < BEAT_BYTES; j++)
                mem_q[{word_idx, LANE_W'(j)}] <= word_wdata[8*j +: 8];
    end

    assign byte_rdata = mem_q[byte_idx];

    // Assemble a beat from its byte lanes
    for (genvar j = 0; j < BEAT_BYTES; j++) begin : g_lane
        assign word_rdata[8*j +: 8] = mem_q[{word_idx, LANE_W'(j)}];
    end
endmodule

// File: rtl/pdma_seq.sv
// Phase sequencer: runs one internal (flash<->buffer) or memory
// (buffer<->host) phase over a full page, then reports done or error and
// idles. Assumes start/stop pulses come from the register decoder.
module pdma_seq #(
    parameter int PAGE_BYTES = 512,
    parameter int BEAT_BYTES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_int,
    input  logic                          start_mem,
    input  logic                          stop,
    input  logic                          dir_read,
    input  logic                          flash_rdy,
    input  logic                          mem_ack,
    input  logic                          mem_err,
    output logic                          flash_rd,
    output logic                          flash_wr,
    output logic                          byte_we,
    output logic [$clog2(PAGE_BYTES)-1:0] byte_idx,
    output logic                          word_we,
    output logic [$clog2(PAGE_BYTES/BEAT_BYTES)-1:0] word_idx,
    output logic                          mem_req,
    output logic                          mem_we,
    output logic                          addr_inc,
    output logic                          ev_int_done,
    output logic                          ev_mem_done,
    output logic                          ev_err
);
    import pdma_pkg::*;

    localparam int BEATS  = PAGE_BYTES / BEAT_BYTES;
    localparam int CNT_W  = $clog2(PAGE_BYTES);
    localparam int BEAT_W = $clog2(BEATS);

    phase_t           ph_q;
    logic [CNT_W-1:0] cnt_q;
    logic             byte_go;
    logic             beat_go;

    // Handshakes and events of the active phase
    always_comb begin
        byte_go     = (ph_q == PH_INT) && flash_rdy;
        flash_rd    = byte_go && dir_read;
        flash_wr    = byte_go && !dir_read;
        byte_we     = flash_rd;
        byte_idx    = cnt_q;
        mem_req     = (ph_q == PH_MEM);
        mem_we      = dir_read;
        beat_go     = mem_req && mem_ack && !mem_err;
        word_we     = beat_go && !dir_read;
        word_idx    = cnt_q[BEAT_W-1:0];
        addr_inc    = beat_go;
        ev_err      = mem_req && mem_err;
        ev_int_done = byte_go && (cnt_q == CNT_W'(PAGE_BYTES - 1));
        ev_mem_done = beat_go && (cnt_q == CNT_W'(BEATS - 1));
    end

    // Phase state and byte/beat counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else if (start_int) begin
            ph_q  <= PH_INT;
            cnt_q <= '0;
        end else if (start_mem) begin
            ph_q  <= PH_MEM;
            cnt_q <= '0;
        end else if (stop) begin
            ph_q  <= PH_IDLE;
        end else if (ev_int_done || ev_mem_done || ev_err) begin
            ph_q  <= PH_IDLE;
        end else if (byte_go || beat_go) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/page_dma_engine.sv
// Top of the two-phase page transfer engine: registers, sequencer and page
// buffer. Host addresses are expected page-aligned; one transfer is one page.
module page_dma_engine #(
    parameter int PAGE_BYTES = 512,
    parameter int DATA_W     = 32,
    parameter int BEAT_BYTES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic              flash_rdy,
    output logic              flash_rd,
    input  logic [7:0]        flash_rdata,
    output logic              flash_wr,
    output logic [7:0]        flash_wdata
);
    localparam int CNT_W  = $clog2(PAGE_BYTES);
    localparam int BEAT_W = $clog2(PAGE_BYTES / BEAT_BYTES);

    logic              addr_inc, ev_int_done, ev_mem_done, ev_err;
    logic              dir_read, start_int, start_mem, stop;
    logic              byte_we, word_we;
    logic [CNT_W-1:0]  byte_idx;
    logic [BEAT_W-1:0] word_idx;

    pdma_regs #(.DATA_W(DATA_W), .BEAT_BYTES(BEAT_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .addr_inc(addr_inc),
        .ev_int_done(ev_int_done), .ev_mem_done(ev_mem_done), .ev_err(ev_err),
        .dir_read(dir_read), .start_int(start_int), .start_mem(start_mem),
        .stop(stop), .cur_addr(mem_addr), .irq(irq)
    );

    pdma_seq #(.PAGE_BYTES(PAGE_BYTES), .BEAT_BYTES(BEAT_BYTES)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_int(start_int), .start_mem(start_mem),
        .stop(stop), .dir_read(dir_read), .flash_rdy(flash_rdy),
        .mem_ack(mem_ack), .mem_err(mem_err), .flash_rd(flash_rd),
        .flash_wr(flash_wr), .byte_we(byte_we), .byte_idx(byte_idx),
        .word_we(word_we), .word_idx(word_idx), .mem_req(mem_req),
        .mem_we(mem_we), .addr_inc(addr_inc), .ev_int_done(ev_int_done),
        .ev_mem_done(ev_mem_done), .ev_err(ev_err)
    );

    pdma_pagebuf #(.PAGE_BYTES(PAGE_BYTES), .BEAT_BYTES(BEAT_BYTES)) u_buf (
        .clk(clk), .byte_we(byte_we), .byte_idx(byte_idx),
        .byte_wdata(flash_rdata), .byte_rdata(flash_wdata),
        .word_we(word_we), .word_idx(word_idx), .word_wdata(mem_rdata),
        .word_rdata(mem_wdata)
    );
endmodule

// File: rtl/pdma_chk.sv
// Checker for the page transfer engine, observing its ports only.
module pdma_chk #(
    parameter int DATA_W     = 32,
    parameter int BEAT_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [1:0]        reg_addr,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_err,
    input logic [DATA_W-1:0] mem_addr,
    input logic              flash_rdy,
    input logic              flash_rd,
    input logic              flash_wr
);
    AST_FLASH_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !(flash_rd && flash_wr)); // R3
    AST_FLASH_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_rd || flash_wr) |-> flash_rdy); // R3
    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && (flash_rd || flash_wr))); // R2
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !mem_err && !reg_we) |=> (mem_req && $stable(mem_addr))); // R4
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_err && !(reg_we && reg_addr == 2'd1))
        |=> (mem_addr == $past(mem_addr) + DATA_W'(BEAT_BYTES))); // R5
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_err && !reg_we) |=> !mem_req); // R7
endmodule

bind page_dma_engine pdma_chk #(.DATA_W(DATA_W), .BEAT_BYTES(BEAT_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_addr(mem_addr), .flash_rdy(flash_rdy), .flash_rd(flash_rd),
    .flash_wr(flash_wr)
);

// File: tb/page_dma_engine_bench.sv
module page_dma_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, mem_req, mem_we, flash_rd, flash_wr;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ack, mem_err;
    logic        flash_rdy = 1'b0;
    logic [7:0]  flash_rdata, flash_wdata;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    page_dma_engine u_page_dma_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .mem_err(mem_err), .flash_rdy(flash_rdy), .flash_rd(flash_rd),
        .flash_rdata(flash_rdata), .flash_wr(flash_wr), .flash_wdata(flash_wdata)
    );

    // ---------------- models ----------------
    logic [7:0]  fseed = 8'h00;
    logic [7:0]  wseed = 8'h00;
    int          fidx = 0;
    int          wcnt = 0;
    logic [7:0]  wcap [512];
    logic [31:0] host [1024];
    logic        ack_q = 1'b0;
    int          beat_n = 0;
    int          err_at = 32'h7fffffff;
    int          cyc = 0;

    function automatic logic [7:0] fpat(int k, logic [7:0] s);
        return 8'(k * 13) + s;
    endfunction
    function automatic logic [31:0] rdpat(logic [31:0] a, logic [7:0] s);
        return (a * 32'h9E3779B1) ^ {4{s}};
    endfunction

    assign flash_rdata = fpat(fidx, fseed);
    assign mem_err     = ack_q && (beat_n == err_at);
    assign mem_ack     = ack_q && !mem_err;
    assign mem_rdata   = rdpat(mem_addr, wseed);

    always @(posedge clk) begin
        if (flash_rd) fidx <= fidx + 1;
        if (flash_wr) begin
            wcap[wcnt % 512] <= flash_wdata;
            wcnt <= wcnt + 1;
        end
        if (mem_req && mem_ack && mem_we) host[mem_addr[11:2]] <= mem_wdata;
        if (mem_req && ack_q) beat_n <= beat_n + 1;
        ack_q <= mem_req && !ack_q;
    end

    always @(negedge clk) begin
        cyc <= cyc + 1;
        flash_rdy <= (cyc % 4) != 3;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_sta(input logic [31:0] mask);
        logic [31:0] s;
        for (int i = 0; i < 4000; i++) begin
            rd(2'd3, s);
            if ((s & mask) != 0) break;
        end
    endtask

    // {dir_read, host address, seed}
    localparam logic [40:0] VEC [4] = '{
        {1'b1, 32'h0000_0200, 8'h11},
        {1'b0, 32'h0000_0400, 8'h5A},
        {1'b1, 32'h0000_0600, 8'hC3},
        {1'b0, 32'h0000_0000, 8'h07}
    };

    initial begin
        logic [31:0] v, a, s, exp_w, keep;
        int base, bad, f0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        bad = 0;
        for (int r = 0; r < 4; r++) begin
            rd(2'(r), v);
            if (v != 0) bad++;
        end
        chk(bad == 0, "R1 registers zero", 32'(bad), 0);
        chk(!irq && !mem_req && !flash_rd && !flash_wr, "R1 outputs idle",
            {28'd0, irq, mem_req, flash_rd, flash_wr}, 0);

        wr(2'd2, 32'h7);
        // Table of full page round trips
        for (int e = 0; e < 4; e++) begin
            a = VEC[e][39:8];
            wr(2'd1, a);
            if (VEC[e][40]) begin
                fseed = VEC[e][7:0];
                base = fidx;
                wr(2'd0, 32'h3);                         // read, internal
                wait_sta(32'h7);
                rd(2'd3, s);
                chk(s == 32'h1 && irq, "R6 R9 internal done", s, 1);
                wr(2'd3, 32'h7);
                wr(2'd0, 32'h5);                         // read, memory
                wait_sta(32'h7);
                rd(2'd3, s);
                chk(s == 32'h2, "R6 memory done", s, 2);
                bad = 0;
                for (int i = 0; i < 128; i++) begin
                    exp_w = {fpat(base + 4*i + 3, fseed), fpat(base + 4*i + 2, fseed),
                             fpat(base + 4*i + 1, fseed), fpat(base + 4*i, fseed)};
                    if (host[(a >> 2) + i] != exp_w) bad++;
                end
                chk(bad == 0, "R3 R4 read page data", 32'(bad), 0);
            end else begin
                wseed = VEC[e][7:0];
                wr(2'd0, 32'h4);                         // write, memory
                wait_sta(32'h7);
                rd(2'd3, s);
                chk(s == 32'h2, "R6 memory done", s, 2);
                wr(2'd3, 32'h7);
                base = wcnt;
                wr(2'd0, 32'h2);                         // write, internal
                wait_sta(32'h7);
                rd(2'd3, s);
                chk(s == 32'h1, "R6 internal done", s, 1);
                bad = 0;
                for (int k = 0; k < 512; k++) begin
                    exp_w = rdpat(a + 32'(4 * (k / 4)), wseed) >> (8 * (k % 4));
                    if (wcap[(base + k) % 512] != exp_w[7:0]) bad++;
                end
                chk(bad == 0, "R3 R4 write page data", 32'(bad), 0);
            end
            rd(2'd1, v);
            chk(v == a + 32'd512, "R5 address advanced by one page", v, a + 32'd512);
            wr(2'd3, 32'h7);
        end

        // R6: idle after done
        f0 = fidx;
        repeat (20) @(negedge clk);
        chk(fidx == f0 && !mem_req, "R6 idle after done", 32'(fidx - f0), 0);

        // R9 / R8: masking and partial clear
        wr(2'd2, 32'h0);
        wr(2'd0, 32'h3);
        wait_sta(32'h1);
        @(negedge clk);
        chk(!irq, "R9 masked status gives no irq", {31'd0, irq}, 0);
        wr(2'd2, 32'h1);
        chk(irq, "R9 enabled status gives irq", {31'd0, irq}, 1);
        wr(2'd3, 32'h2);
        rd(2'd3, s);
        chk(s == 32'h1, "R8 writing zero bit keeps status", s, 1);
        wr(2'd1, 32'h0000_0800);
        wr(2'd0, 32'h5);
        wait_sta(32'h2);
        wr(2'd3, 32'h1);
        rd(2'd3, s);
        chk(s == 32'h2, "R8 partial clear", s, 2);
        wr(2'd3, 32'h7);

        // R7: error on sixth beat
        wr(2'd2, 32'h4);
        wr(2'd1, 32'h0000_0C00);
        keep = host[(32'h0C00 >> 2) + 5];
        err_at = beat_n + 5;
        wr(2'd0, 32'h5);
        wait_sta(32'h4);
        @(negedge clk);
        rd(2'd3, s);
        chk(s == 32'h4 && irq, "R7 error status", s, 4);
        rd(2'd1, v);
        chk(v == 32'h0C14, "R7 address stops at failed beat", v, 32'h0C14);
        chk(host[(32'h0C00 >> 2) + 5] == keep, "R7 failed beat not stored",
            host[(32'h0C00 >> 2) + 5], keep);
        chk(!mem_req, "R7 engine idle after error", {31'd0, mem_req}, 0);
        err_at = 32'h7fffffff;
        wr(2'd3, 32'h7);

        // R10: stop mid-phase
        wr(2'd0, 32'h3);
        repeat (10) @(negedge clk);
        wr(2'd0, 32'h0);
        f0 = fidx;
        repeat (40) @(negedge clk);
        rd(2'd3, s);
        chk(fidx == f0 && s == 0, "R10 stop ends activity, no status", s, 0);

        // R2: both phase bits set is not a start
        f0 = fidx;
        wr(2'd0, 32'h7);
        repeat (30) @(negedge clk);
        rd(2'd3, s);
        chk(fidx == f0 && !mem_req && s == 0, "R2 invalid settings ignored",
            32'(fidx - f0), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule